// File: doc/BRIEF.md
# Multiplexed LCD Row Scan and Drive-Level Sequencer

This block turns an externally supplied frame-rate square wave into the per-pin drive decisions of a 2-, 4- or 8-way multiplexed LCD. One row of the glass is active for each full period of the frame-rate wave. The block keeps a row counter that names the active row. That counter also serves as the read address of the display memory. From the returned memory word, the current polarity and the operating mode, it emits a three-bit level-select code for each of the drive pins. An analog bias network downstream turns each code into a voltage.

The frame-rate wave and the strobe arrive asynchronously, so both pass through two-flop synchronisers before use. A falling edge of the synchronised frame-rate wave moves the scan to the next row. Raising the strobe has two effects: while it is high every pin is parked at the top supply level, and it makes the next falling edge restart the scan at the first row. This is how several drivers on one panel are brought into step. A column-only mode input turns every pin into a column pin, for the cascaded drivers that do not scan rows.

Top module: `lcdmux_seq`

## Requirements
- R1: After reset the row address is 0 and the polarity is low. With the strobe low, pin 0 (the active row) shows code 0 (bottom supply) and the other row pins show code 3 (upper inner level).
- R2: A change of the frame-rate input reaches the drive codes three clock edges after it is first sampled, and no earlier.
- R3: The row address advances by one on each falling edge of the synchronised frame-rate signal. A rising edge leaves it unchanged, as does any cycle with no edge.
- R4: The row address wraps from MUX-1 to 0 on a falling edge. It never leaves the range 0..MUX-1.
- R5: If the synchronised strobe has been high in any cycle since the previous falling edge, or is high at the edge itself, the next falling edge sets the row address to 0.
- R6: While the synchronised strobe is high, every pin shows code 4 (top supply). The strobe takes effect two clock edges after it is sampled.
- R7: With column-only mode low, pins 0..MUX-1 are row pins. The active row shows code 4 when the polarity is high and code 0 when it is low. An inactive row shows the lower inner level when the polarity is high and code 3 when it is low.
- R8: Each column pin g takes bit g of the memory word. A set bit gives code 0 at high polarity and code 4 at low polarity. A clear bit gives code 3 at high polarity and the lower inner level at low polarity.
- R9: With column-only mode high, all pins, including 0..MUX-1, follow the column rule of R8.
- R10: The lower inner level is code 2 when MUX is 4 and code 1 when MUX is 2 or 8. The full code set is 0 bottom supply, 1 lowest inner level, 2 middle inner level, 3 upper inner level, 4 top supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fr_in | input | 1 | Frame-rate square wave, asynchronous |
| strobe_in | input | 1 | Blank and resynchronise request, asynchronous |
| col_only | input | 1 | High: every pin is a column pin |
| ram_rdata | input | NUM_OUT | Display memory word read at row_addr |
| row_addr | output | RW | Active row, also the display memory read address |
| lvl_sel | output | 3*NUM_OUT | Level code per pin; pin g is bits 3g+2..3g |

## Verification
The hardest case to reach is a resynchronisation that is requested but not yet carried out. This happens when a short strobe pulse rises and falls in the middle of an FR half-period. The pulse must be remembered until the next falling edge, and it must restart the scan even though the strobe is low by then. The stimulus places strobe pulses of a few clocks inside the low and high halves of FR. It also uses a long strobe that spans several edges. A cycle-accurate reference running the same pattern on a 4-way and an 8-way instance shows whether the memory, the restart and the return from blanking all line up.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;
  localparam int LW = 3;

  typedef enum logic [LW-1:0] {
    LVL_VSS  = 3'd0,
    LVL_V3   = 3'd1,
    LVL_V2   = 3'd2,
    LVL_V1   = 3'd3,
    LVL_VLCD = 3'd4
  } lvl_e;

  // lower inner level depends on the bias scheme of the multiplex ratio
  function automatic lvl_e lower_inner(input int mux);
    return (mux == 4) ? LVL_V2 : LVL_V3;
  endfunction
endpackage

// File: rtl/lcdmux_rst_sync.sv
module lcdmux_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_int_n = out_q;
endmodule

// File: rtl/lcdmux_sync.sv
module lcdmux_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/lcdmux_row_ctr.sv
module lcdmux_row_ctr #(
  parameter int MUX = 8,
  localparam int RW = (MUX > 2) ? $clog2(MUX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fr_s,
  input  logic          blank_s,
  output logic          pol,
  output logic          fr_fall,
  output logic          resync_req,
  output logic [RW-1:0] row
);
  localparam logic [RW-1:0] LAST = RW'(MUX - 1);

  logic          fr_q;
  logic [RW-1:0] row_q, row_d;
  logic          req_q, req_d;
  logic          row_en;

  assign fr_fall = fr_q & ~fr_s;
  assign row_en  = fr_fall;

  // next state
  always_comb begin
    row_d = row_q;
    req_d = req_q;
    if (fr_fall) begin
      req_d = 1'b0;
      if (req_q || blank_s)  row_d = '0;
      else if (row_q == LAST) row_d = '0;
      else                    row_d = row_q + RW'(1);
    end else if (blank_s) begin
      req_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q  <= 1'b0;
      row_q <= '0;
      req_q <= 1'b0;
    end else begin
      fr_q  <= fr_s;
      req_q <= req_d;
      if (row_en) row_q <= row_d;
    end
  end

  assign pol        = fr_q;
  assign resync_req = req_q;
  assign row        = row_q;
endmodule

// File: rtl/lcdmux_drv.sv
module lcdmux_drv
  import lcdmux_pkg::*;
#(
  parameter int MUX     = 8,
  parameter int NUM_OUT = 40,
  localparam int RW = (MUX > 2) ? $clog2(MUX) : 1
) (
  input  logic [RW-1:0]         row,
  input  logic                  pol,
  input  logic                  blank,
  input  logic                  col_only,
  input  logic [NUM_OUT-1:0]    ram_rdata,
  output logic [NUM_OUT*LW-1:0] lvl_sel
);
  localparam lvl_e LO_IN = lower_inner(MUX);
  localparam lvl_e HI_IN = LVL_V1;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
    lvl_e col_lvl;
    lvl_e pin_lvl;

    always_comb begin
      if (ram_rdata[g]) col_lvl = pol ? LVL_VSS : LVL_VLCD;
      else              col_lvl = pol ? HI_IN   : LO_IN;
    end

    if (g < MUX) begin : g_row
      lvl_e row_lvl;
      always_comb begin
        if (row == RW'(g)) row_lvl = pol ? LVL_VLCD : LVL_VSS;
        else               row_lvl = pol ? LO_IN    : HI_IN;
      end
      always_comb begin
        if (blank)          pin_lvl = LVL_VLCD;
        else if (col_only)  pin_lvl = col_lvl;
        else                pin_lvl = row_lvl;
      end
    end else begin : g_col
      always_comb begin
        if (blank) pin_lvl = LVL_VLCD;
        else       pin_lvl = col_lvl;
      end
    end

    assign lvl_sel[g*LW +: LW] = pin_lvl;
  end
endmodule

// File: rtl/lcdmux_seq.sv
module lcdmux_seq
  import lcdmux_pkg::*;
#(
  parameter int MUX     = 8,
  parameter int NUM_OUT = 40,
  localparam int RW = (MUX > 2) ? $clog2(MUX) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fr_in,
  input  logic                  strobe_in,
  input  logic                  col_only,
  input  logic [NUM_OUT-1:0]    ram_rdata,
  output logic [RW-1:0]         row_addr,
  output logic [NUM_OUT*LW-1:0] lvl_sel
);
  logic       rst_int_n;
  logic [1:0] sync_out;
  logic       fr_s;
  logic       blank_s;
  logic       pol;
  logic       fr_fall;
  logic       resync_req;

  lcdmux_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  lcdmux_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async ({strobe_in, fr_in}),
    .q_sync  (sync_out)
  );

  assign fr_s    = sync_out[0];
  assign blank_s = sync_out[1];

  lcdmux_row_ctr #(.MUX(MUX)) u_row (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .fr_s       (fr_s),
    .blank_s    (blank_s),
    .pol        (pol),
    .fr_fall    (fr_fall),
    .resync_req (resync_req),
    .row        (row_addr)
  );

  lcdmux_drv #(.MUX(MUX), .NUM_OUT(NUM_OUT)) u_drv (
    .row       (row_addr),
    .pol       (pol),
    .blank     (blank_s),
    .col_only  (col_only),
    .ram_rdata (ram_rdata),
    .lvl_sel   (lvl_sel)
  );
endmodule

// File: rtl/lcdmux_seq_chk.sv
module lcdmux_seq_chk #(
  parameter int MUX     = 8,
  parameter int NUM_OUT = 40,
  localparam int RW = (MUX > 2) ? $clog2(MUX) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fr_fall,
  input logic                  resync_req,
  input logic                  blank_s,
  input logic                  pol,
  input logic                  col_only,
  input logic [RW-1:0]         row_addr,
  input logic [NUM_OUT*3-1:0]  lvl_sel
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_fall |=> $stable(row_addr));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_fall && !resync_req && !blank_s) |=>
      (int'(row_addr) == ((int'($past(row_addr)) + 1) % MUX)));

  p_resync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_fall && (resync_req || blank_s)) |=> (row_addr == '0));

  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blank_s |-> (lvl_sel == {NUM_OUT{3'd4}}));

  p_sel_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_s && !col_only) |->
      (lvl_sel[int'(row_addr)*3 +: 3] == (pol ? 3'd4 : 3'd0)));
endmodule

bind lcdmux_seq lcdmux_seq_chk #(.MUX(MUX), .NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fr_fall    (fr_fall),
  .resync_req (resync_req),
  .blank_s    (blank_s),
  .pol        (pol),
  .col_only   (col_only),
  .row_addr   (row_addr),
  .lvl_sel    (lvl_sel)
);

// File: tb/lcdmux_seq_bench.sv
module lcdmux_seq_bench;
  localparam int NO = 40;

  logic clk;
  logic rst_n;
  logic fr_in;
  logic strobe_in;
  logic col_only;
  logic [2:0]    row8;
  logic [1:0]    row4;
  logic [NO-1:0] ram8, ram4;
  logic [NO*3-1:0] lvl8, lvl4;
  logic [NO-1:0] mem8 [8];
  logic [NO-1:0] mem4 [4];

  int tests, fails;
  bit cmp_en;

  // reference state: index 0 = 8-way, 1 = 4-way
  bit fh [3];
  bit sh [3];
  int mrow [2];
  bit mreq [2];
  int mevt [2];
  int cyc;

  assign ram8 = mem8[row8];
  assign ram4 = mem4[row4];

  lcdmux_seq #(.MUX(8), .NUM_OUT(NO)) u_lcdmux_seq (
    .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .strobe_in(strobe_in),
    .col_only(col_only), .ram_rdata(ram8), .row_addr(row8), .lvl_sel(lvl8));

  lcdmux_seq #(.MUX(4), .NUM_OUT(NO)) u_lcdmux_seq_m4 (
    .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .strobe_in(strobe_in),
    .col_only(col_only), .ram_rdata(ram4), .row_addr(row4), .lvl_sel(lvl4));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_lvl(int mux, int g, bit pol, bit blank,
                                 bit col, bit rambit, int row);
    int lo;
    lo = (mux == 4) ? 2 : 1;
    if (blank) return 4;
    if (!col && g < mux) begin
      if (g == row) return pol ? 4 : 0;
      return pol ? lo : 3;
    end
    if (rambit) return pol ? 0 : 4;
    return pol ? 3 : lo;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin fh[i] = 1'b0; sh[i] = 1'b0; end
      for (int m = 0; m < 2; m++) begin mrow[m] = 0; mreq[m] = 1'b0; mevt[m] = 0; end
    end else begin
      bit fall, bpre;
      fall = !fh[1] && fh[2];
      bpre = sh[1];
      for (int m = 0; m < 2; m++) begin
        int mux;
        mux = (m == 0) ? 8 : 4;
        if (fall) begin
          if (mreq[m] || bpre) begin mrow[m] = 0; mevt[m] = 2; end
          else if (mrow[m] == mux - 1) begin mrow[m] = 0; mevt[m] = 1; end
          else begin mrow[m] = mrow[m] + 1; mevt[m] = 0; end
          mreq[m] = 1'b0;
        end else if (bpre) begin
          mreq[m] = 1'b1;
        end
      end
      fh[2] = fh[1]; fh[1] = fh[0]; fh[0] = fr_in;
      sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = strobe_in;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int m = 0; m < 2; m++) begin
        int mux, arow, first_g, first_a, first_e;
        bit ok;
        string tag;
        mux  = (m == 0) ? 8 : 4;
        arow = (m == 0) ? int'(row8) : int'(row4);
        tag  = (mevt[m] == 2) ? "R5 row" : (mevt[m] == 1) ? "R4 row" : "R3 row";
        check(arow == mrow[m], tag, arow, mrow[m]);
        ok = 1'b1; first_g = -1; first_a = 0; first_e = 0;
        for (int g = 0; g < NO; g++) begin
          int a, e;
          bit rb;
          rb = (m == 0) ? mem8[mrow[m]][g] : mem4[mrow[m]][g];
          a  = (m == 0) ? int'(lvl8[g*3 +: 3]) : int'(lvl4[g*3 +: 3]);
          e  = exp_lvl(mux, g, fh[2], sh[1], col_only, rb, mrow[m]);
          if (ok && a != e) begin ok = 1'b0; first_g = g; first_a = a; first_e = e; end
        end
        if (sh[1]) tag = "R6 level";
        else if (first_g >= 0 && first_g < mux && !col_only) tag = (m == 1) ? "R10 level" : "R7 level";
        else if (col_only) tag = "R9 level";
        else tag = "R8 level";
        check(ok, tag, first_a, first_e);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic fr_period(int half);
    fr_in = 1'b1;
    repeat (half) @(negedge clk);
    fr_in = 1'b0;
    repeat (half) @(negedge clk);
  endtask

  initial begin
    tests = 0; fails = 0; cmp_en = 1'b0; cyc = 0;
    fr_in = 1'b0; strobe_in = 1'b0; col_only = 1'b0; rst_n = 1'b0;
    for (int r = 0; r < 8; r++) mem8[r] = 40'hA5C396E10F ^ (40'h1 << (r * 5));
    for (int r = 0; r < 4; r++) mem4[r] = 40'h3C5AF0129B ^ (40'h3 << (r * 9));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check(row8 == 3'd0, "R1 row", int'(row8), 0);
    check(lvl8[2:0] == 3'd0, "R1 active row pin", int'(lvl8[2:0]), 0);
    check(lvl8[5:3] == 3'd3, "R1 idle row pin", int'(lvl8[5:3]), 3);
    check(lvl4[5:3] == 3'd3, "R1 idle row pin m4", int'(lvl4[5:3]), 3);
    cmp_en = 1'b1;

    // R2 latency of FR to the drive codes
    fr_in = 1'b1;
    repeat (2) @(negedge clk);
    check(lvl8[2:0] == 3'd0, "R2 before third edge", int'(lvl8[2:0]), 0);
    @(negedge clk);
    check(lvl8[2:0] == 3'd4, "R2 at third edge", int'(lvl8[2:0]), 4);
    repeat (3) @(negedge clk);
    fr_in = 1'b0;
    repeat (6) @(negedge clk);

    // R3 R4 full sweeps
    for (int p = 0; p < 18; p++) fr_period(5);
    repeat (4) @(negedge clk);
    // 19 falling edges so far: 19 mod 8 = 3, 19 mod 4 = 3
    check(row8 == 3'd3, "R4 wrap count m8", int'(row8), 3);
    check(row4 == 2'd3, "R4 wrap count m4", int'(row4), 3);

    // R5 short strobe inside the high half, gone before the fall
    fr_in = 1'b1;
    repeat (2) @(negedge clk);
    strobe_in = 1'b1;
    @(negedge clk);
    strobe_in = 1'b0;
    repeat (5) @(negedge clk);
    fr_in = 1'b0;
    repeat (4) @(negedge clk);
    check(row8 == 3'd0, "R5 remembered strobe", int'(row8), 0);
    repeat (4) @(negedge clk);
    for (int p = 0; p < 5; p++) fr_period(6);

    // R5 R6 long strobe across several edges
    strobe_in = 1'b1;
    repeat (2) @(negedge clk);
    check(lvl8 == {NO{3'd4}}, "R6 blank all pins", int'(lvl8[2:0]), 4);
    for (int p = 0; p < 3; p++) fr_period(4);
    strobe_in = 1'b0;
    for (int p = 0; p < 3; p++) fr_period(4);

    // R9 column-only mode with new memory contents
    col_only = 1'b1;
    for (int r = 0; r < 8; r++) mem8[r] = ~mem8[r];
    for (int p = 0; p < 10; p++) fr_period(5);
    col_only = 1'b0;

    // short strobe inside the low half
    fr_in = 1'b1;
    repeat (5) @(negedge clk);
    fr_in = 1'b0;
    repeat (2) @(negedge clk);
    strobe_in = 1'b1;
    repeat (2) @(negedge clk);
    strobe_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 10; p++) fr_period(3);
    repeat (6) @(negedge clk);

    cmp_en = 1'b0;
    summary();
  end
endmodule